// File: doc/BRIEF.md
# Ring-Rotation Block Matrix Multiplier

This block computes the product C = A x B of two square matrices of signed fixed-point integers. The work is spread over a ring of processing elements, and the number of elements is set at build time. Each element permanently keeps one horizontal slice of A, a band of rows. It starts with the matching vertical slice of B, a band of columns. In every phase each element builds the output tile for the A slice and the B slice it holds at that moment, using one multiply-accumulate unit. While that work goes on, the B slice it is using streams to the next element in the ring. When the phase ends, every element swaps to the slice it has just received. After as many phases as there are elements, each element has met every B slice, and all of C is in place.

To use the block, the host writes every element of A and B through the load port while the block is idle. It then pulses start and waits for the one-cycle done pulse. After that it reads C one entry at a time through a registered read port. The B slices end up back at their home elements after a full run. A second start with no reload therefore computes the same product again.

Top module: `mm_ring_top`

## Requirements
- R1: After reset, busy and done are 0 and rd_data is 0.
- R2: While busy is 0, a cycle with ld_en high writes ld_data to A[ld_row][ld_col] when ld_sel is 0, and to B[ld_row][ld_col] when ld_sel is 1. Row index 0 is the top row and column index 0 is the left column.
- R3: A start pulse sampled while busy is 0 begins a run. Every C[i][j] then equals the exact signed sum over k of A[i][k]*B[k][j], held in ACC_W-bit two's complement.
- R4: done is high for exactly one cycle, N^3/P clock edges after the edge that samples start. With the default parameters that is 128 edges. busy is high from the edge after start until done rises, and it is low while done is high.
- R5: start is ignored while busy is 1. It neither restarts nor lengthens the run.
- R6: ld_en is ignored while busy is 1. Neither the running product nor any later run sees the write.
- R7: B slices rotate through a second bank in each element, and the banks swap at each phase boundary. A run with distinct B slices gives the correct product. A second start with no reload gives the same C as the first run.
- R8: rd_data shows C[rd_row][rd_col] one clock edge after the address is presented.
- R9: Operands at the extremes of the signed range (-32768, 32767) accumulate exactly. For example, eight products of -32768 x -32768 give 8589934592.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe for one matrix element |
| ld_sel | input | 1 | 0 selects A, 1 selects B |
| ld_row | input | $clog2(N) | Row index of the element loaded |
| ld_col | input | $clog2(N) | Column index of the element loaded |
| ld_data | input | DW | Signed element value |
| start | input | 1 | Begin a run (used only when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_row | input | $clog2(N) | Row of C to read |
| rd_col | input | $clog2(N) | Column of C to read |
| rd_data | output | ACC_W | Signed C entry, registered |

## Verification
Almost any internal fault in this block turns into wrong values in C, so the bench compares every entry against a product it computes itself.

- A wrong bank select, a wrong ring neighbour, or a wrong tile column from the phase count each corrupt whole column blocks. This shows up at the read port as soon as the run finishes.
- A load that gets through while busy is high can slip past the current product. It does show up when the second run reuses the stored operands.
- A wrong phase or step counter changes when done rises. The bench checks this against the exact edge count.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic [0:0] {
    MM_IDLE = 1'b0,
    MM_RUN  = 1'b1
  } mm_state_e;

  typedef enum logic [0:0] {
    MM_SEL_A = 1'b0,
    MM_SEL_B = 1'b1
  } mm_sel_e;

endpackage

// File: rtl/mm_ring_ctrl.sv
module mm_ring_ctrl
  import mm_pkg::*;
#(
  parameter int N = 8,
  parameter int P = 4,
  localparam int R  = N / P,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int RW = (R > 1) ? $clog2(R) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run,
  output logic          done,
  output logic          bank,
  output logic [PW-1:0] phase,
  output logic [RW-1:0] r_idx,
  output logic [RW-1:0] c_idx,
  output logic [IW-1:0] k_idx,
  output logic          fill_en
);

  mm_state_e     st_q, st_d;
  logic          done_q, done_d;
  logic          bank_q, bank_d;
  logic [PW-1:0] ph_q, ph_d;
  logic [RW-1:0] r_q, r_d, c_q, c_d;
  logic [IW-1:0] k_q, k_d;

  logic last_k, last_c, last_r, last_ph, phase_end;

  assign last_k    = (k_q == IW'(N - 1));
  assign last_c    = (c_q == RW'(R - 1));
  assign last_r    = (r_q == RW'(R - 1));
  assign last_ph   = (ph_q == PW'(P - 1));
  assign phase_end = (st_q == MM_RUN) && last_k && last_c && last_r;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    bank_d = bank_q;
    ph_d   = ph_q;
    r_d    = r_q;
    c_d    = c_q;
    k_d    = k_q;
    if (st_q == MM_IDLE) begin
      if (start) begin
        st_d = MM_RUN;
        ph_d = '0;
        r_d  = '0;
        c_d  = '0;
        k_d  = '0;
      end
    end else begin
      k_d = last_k ? '0 : k_q + 1'b1;
      if (last_k) c_d = last_c ? '0 : c_q + 1'b1;
      if (last_k && last_c) r_d = last_r ? '0 : r_q + 1'b1;
      if (phase_end) begin
        bank_d = ~bank_q;
        ph_d   = last_ph ? '0 : ph_q + 1'b1;
        if (last_ph) begin
          st_d   = MM_IDLE;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MM_IDLE;
      done_q <= 1'b0;
      bank_q <= 1'b0;
      ph_q   <= '0;
      r_q    <= '0;
      c_q    <= '0;
      k_q    <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      bank_q <= bank_d;
      ph_q   <= ph_d;
      r_q    <= r_d;
      c_q    <= c_d;
      k_q    <= k_d;
    end
  end

  assign run     = (st_q == MM_RUN);
  assign done    = done_q;
  assign bank    = bank_q;
  assign phase   = ph_q;
  assign r_idx   = r_q;
  assign c_idx   = c_q;
  assign k_idx   = k_q;
  assign fill_en = run && (r_q == '0);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!run && $past(run)));
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(phase_end && last_ph)) |=> run);
  p_bank_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phase_end |=> (bank != $past(bank)));
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !phase_end) |=> $stable(bank));

endmodule

// File: rtl/mm_ring_pe.sv
module mm_ring_pe #(
  parameter int IDX   = 0,
  parameter int N     = 8,
  parameter int P     = 4,
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  localparam int R  = N / P,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int RW = (R > 1) ? $clog2(R) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_we,
  input  logic [RW-1:0]           a_row,
  input  logic [IW-1:0]           a_col,
  input  logic                    b_we,
  input  logic [IW-1:0]           b_row,
  input  logic [RW-1:0]           b_col,
  input  logic signed [DW-1:0]    wdata,
  input  logic                    run,
  input  logic                    bank,
  input  logic [PW-1:0]           phase,
  input  logic [RW-1:0]           r_idx,
  input  logic [RW-1:0]           c_idx,
  input  logic [IW-1:0]           k_idx,
  input  logic                    fill_en,
  input  logic signed [DW-1:0]    fill_data,
  output logic signed [DW-1:0]    pass_data,
  input  logic [RW-1:0]           rd_lrow,
  input  logic [IW-1:0]           rd_col,
  output logic signed [ACC_W-1:0] rd_val
);

  logic signed [DW-1:0]    amem [R][N];
  logic signed [DW-1:0]    bmem [2][N][R];
  logic signed [ACC_W-1:0] cmem [R][N];

  logic signed [DW-1:0]    a_op, b_op;
  logic signed [2*DW-1:0]  prod;
  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic [IW-1:0]           tile_col;
  int                      jv;

  assign a_op = amem[r_idx][k_idx];
  assign b_op = bmem[bank][k_idx][c_idx];
  assign prod = a_op * b_op;

  always_comb begin
    jv       = (IDX + P - int'(phase)) % P;
    tile_col = IW'(jv * R + int'(c_idx));
    acc_d    = ((k_idx == '0) ? '0 : acc_q)
             + {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (run) acc_q <= acc_d;
  end

  always_ff @(posedge clk) begin
    if (a_we) amem[a_row][a_col] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (fill_en)   bmem[~bank][k_idx][c_idx] <= fill_data;
    else if (b_we) bmem[bank][b_row][b_col]  <= wdata;
  end

  always_ff @(posedge clk) begin
    if (run && (k_idx == IW'(N - 1))) cmem[r_idx][tile_col] <= acc_d;
  end

  assign pass_data = b_op;
  assign rd_val    = cmem[rd_lrow][rd_col];

  p_fill_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> run);
  p_no_load_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we || b_we) |-> !run);

endmodule

// File: rtl/mm_ring_top.sv
module mm_ring_top #(
  parameter int N     = 8,
  parameter int P     = 4,
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  localparam int R  = N / P,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int RW = (R > 1) ? $clog2(R) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_en,
  input  logic                    ld_sel,
  input  logic [IW-1:0]           ld_row,
  input  logic [IW-1:0]           ld_col,
  input  logic signed [DW-1:0]    ld_data,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  input  logic [IW-1:0]           rd_row,
  input  logic [IW-1:0]           rd_col,
  output logic signed [ACC_W-1:0] rd_data
);

  logic          run, bank, fill_en;
  logic [PW-1:0] phase;
  logic [RW-1:0] r_idx, c_idx;
  logic [IW-1:0] k_idx;

  logic [PW-1:0] a_owner, b_owner, rd_owner;
  logic [RW-1:0] a_lrow, b_lcol, rd_lrow;
  logic          ld_ok;

  logic signed [DW-1:0]    pass_w [P];
  logic signed [ACC_W-1:0] rd_w   [P];
  logic signed [ACC_W-1:0] rd_q;

  mm_ring_ctrl #(.N(N), .P(P)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .run(run), .done(done), .bank(bank), .phase(phase),
    .r_idx(r_idx), .c_idx(c_idx), .k_idx(k_idx), .fill_en(fill_en)
  );

  always_comb begin
    ld_ok    = ld_en && !run;
    a_owner  = PW'(int'(ld_row) / R);
    a_lrow   = RW'(int'(ld_row) % R);
    b_owner  = PW'(int'(ld_col) / R);
    b_lcol   = RW'(int'(ld_col) % R);
    rd_owner = PW'(int'(rd_row) / R);
    rd_lrow  = RW'(int'(rd_row) % R);
  end

  for (genvar g = 0; g < P; g++) begin : g_pe
    localparam int PREV = (g + P - 1) % P;
    logic a_we_g, b_we_g;
    assign a_we_g = ld_ok && (ld_sel == mm_pkg::MM_SEL_A) && (a_owner == PW'(g));
    assign b_we_g = ld_ok && (ld_sel == mm_pkg::MM_SEL_B) && (b_owner == PW'(g));

    mm_ring_pe #(.IDX(g), .N(N), .P(P), .DW(DW), .ACC_W(ACC_W)) u_pe (
      .clk(clk), .rst_n(rst_n),
      .a_we(a_we_g), .a_row(a_lrow), .a_col(ld_col),
      .b_we(b_we_g), .b_row(ld_row), .b_col(b_lcol),
      .wdata(ld_data),
      .run(run), .bank(bank), .phase(phase),
      .r_idx(r_idx), .c_idx(c_idx), .k_idx(k_idx),
      .fill_en(fill_en), .fill_data(pass_w[PREV]), .pass_data(pass_w[g]),
      .rd_lrow(rd_lrow), .rd_col(rd_col), .rd_val(rd_w[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_w[rd_owner];
  end

  assign rd_data = rd_q;
  assign busy    = run;

  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

// File: tb/mm_ring_top_bench.sv
module mm_ring_top_bench;

  localparam int N  = 8;
  localparam int P  = 4;
  localparam int DW = 16;
  localparam int AW = 40;
  localparam int RUN_EDGES = N * N * N / P;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
  logic [2:0]    ld_row = '0, ld_col = '0, rd_row = '0, rd_col = '0;
  logic [DW-1:0] ld_data = '0;
  logic          busy, done;
  logic [AW-1:0] rd_data;

  always #10 clk = ~clk;

  mm_ring_top #(.N(N), .P(P), .DW(DW), .ACC_W(AW)) u_mm_ring_top (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
    .busy(busy), .done(done), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    int     row;
    int     col;
    longint val;
    string  req;
  } exp_t;
  exp_t   sb_q[$];
  logic   rd_req = 1'b0;
  logic   rd_req_d = 1'b0;
  longint ma [N][N];
  longint mb [N][N];
  longint mc [N][N];

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_req_d <= rd_req;
  always @(negedge clk) begin
    if (rd_req_d && sb_q.size() > 0) begin
      exp_t e;
      longint got;
      e   = sb_q.pop_front();
      got = longint'($signed(rd_data));
      checks++;
      if (got !== e.val) begin
        errors++;
        $display("FAIL %s C[%0d][%0d]: got %0d expected %0d",
                 e.req, e.row, e.col, got, e.val);
      end
    end
  end

  task automatic compute_expected();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        mc[i][j] = 0;
        for (int k = 0; k < N; k++) mc[i][j] += ma[i][k] * mb[k][j];
      end
  endtask

  task automatic load_all();
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          @(negedge clk);
          ld_en   = 1'b1;
          ld_sel  = s[0];
          ld_row  = 3'(i);
          ld_col  = 3'(j);
          ld_data = (s == 0) ? 16'(ma[i][j]) : 16'(mb[i][j]);
        end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        exp_t e;
        @(negedge clk);
        rd_row = 3'(i);
        rd_col = 3'(j);
        rd_req = 1'b1;
        e.row = i; e.col = j; e.val = mc[i][j]; e.req = req;
        sb_q.push_back(e);
      end
    @(negedge clk);
    rd_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // disturb: pulse start and attempt loads while busy (R5, R6)
  task automatic run_timed(input bit disturb);
    int cyc;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 busy after start", longint'(busy), 1);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (disturb) begin
        start  = (cyc == 5 || cyc == 60);
        ld_en  = (cyc >= 10 && cyc < 20);
        ld_sel = cyc[0];
        ld_row = 3'(cyc % N);
        ld_col = 3'((cyc * 3) % N);
        ld_data = 16'h1234;
      end
      if (done || cyc > 2000) break;
    end
    start = 1'b0;
    ld_en = 1'b0;
    check(disturb ? "R5 done edge count with start/load while busy"
                  : "R4 done edge count", longint'(cyc), longint'(RUN_EDGES));
    check("R4 busy low with done", longint'(busy), 0);
    @(negedge clk);
    check("R4 done one cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy in reset", longint'(busy), 0);
    check("R1 done in reset", longint'(done), 0);
    check("R1 rd_data in reset", longint'(rd_data), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", longint'(busy), 0);
    check("R1 done after reset", longint'(done), 0);

    // identity A, distinct B: C must equal B (R2 mapping, R7 rotation)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i == j) ? 1 : 0;
        mb[i][j] = i * 100 + j * 7 - 300;
      end
    compute_expected();
    load_all();
    run_timed(1'b0);
    read_all("R2 R7 R8 identity");

    // general pattern (R3), disturbed run (R5, R6)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = ((i * 37 + j * 11) % 201) - 100;
        mb[i][j] = ((i * 13 + j * 29 + 7) % 151) - 75;
      end
    compute_expected();
    load_all();
    run_timed(1'b1);
    read_all("R3 R6 product");

    // rerun with no reload (R7, R6)
    run_timed(1'b0);
    read_all("R7 R6 rerun");

    // signed extremes (R9)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ma[i][j] = (i < 4) ? -32768 : ((j % 2 == 0) ? 32767 : -32768);
        mb[i][j] = (j % 3 == 0) ? 32767 : -32768;
      end
    compute_expected();
    check("R9 model corner", mc[0][1], 64'sd8589934592);
    load_all();
    run_timed(1'b0);
    read_all("R9 extremes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule